// File: doc/BRIEF.md
# Effective address generator

This unit turns an addressing-mode code and its instruction operand into the 16-bit effective address used by an 8-bit processor core. On a start pulse it captures the mode, the operand and both index registers. Modes that need only arithmetic finish on the next cycle. Modes that go through a pointer in memory first fetch the two pointer bytes over a simple request/valid read port. When the final address is ready, the unit presents it together with a one-cycle done pulse.

The sequencer reads the low pointer byte first and the high byte second. The core can launch a new request in the same cycle that the previous result is reported. While a pointer fetch is in progress, new start pulses are ignored. The `busy` output tells the core when that is the case.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode codes 0 (implied) and 1 (accumulator), and the unused codes 13 to 15, produce no address. Done pulses on the cycle after start, with addr_valid low and addr at 0x0000, and no read is issued.
- R2: Immediate (code 2) and relative (code 3) return the operand low byte, zero-extended, as the result with addr_valid high. Done follows start by one cycle.
- R3: Zero page (code 4) yields 0x00 followed by the operand low byte. The operand high byte has no effect on the result.
- R4: Zero page indexed by X (code 5) or by Y (code 6) adds the index to the operand low byte modulo 256, so the high result byte is always 0x00.
- R5: Absolute (code 7), absolute+X (code 8) and absolute+Y (code 9) use the full 16-bit operand. The index is added with carry into the high byte, and the sum wraps at 0xFFFF.
- R6: Indexed indirect (code 11) reads the low pointer byte at page-0 address (op+X) mod 256 and the high byte at (op+X+1) mod 256. The pointer is the result.
- R7: Indirect indexed (code 12) reads the low pointer byte at page-0 address op and the high byte at (op+1) mod 256. It then adds Y to the 16-bit pointer with full carry.
- R8: Indirect (code 10) reads the low byte at the 16-bit operand. It reads the high byte at an address with the same high byte and low byte (op+1) mod 256, so no carry enters the page number.
- R9: Each pointer byte takes one handshake. rd_req stays high with a stable rd_addr until a cycle in which rd_valid is high. Exactly two reads are made per pointer mode, low byte first.
- R10: For pointer modes, done pulses on the cycle after the handshake of the high byte. addr and addr_valid hold their value until the next done.
- R11: A start while busy is high is ignored. The running fetch completes with its original inputs, and no extra done follows.
- R12: A start in the same cycle as done is accepted. The new operation runs normally from there.
- R13: After reset, done, rd_req, busy and addr_valid are low and addr is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted when busy is low) |
| mode | input | 4 | Addressing-mode code |
| operand | input | 16 | Instruction operand, low byte in bits 7:0 |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| busy | output | 1 | Pointer fetch in progress |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_valid | input | 1 | Read data valid; completes the handshake |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle result pulse |
| addr | output | 16 | Effective address (or operand value) |
| addr_valid | output | 1 | Result carries an address |

## Verification
Two events can fall in one cycle: a done pulse that reports the finished operation, and a new start. The bench raises start in the very cycle it sees done. It checks that done still shows the earlier address, and that the following cycle shows the new one. A second overlap is a start that arrives while a pointer fetch is stretched by memory latency. That start must leave the running fetch untouched: the bench expects exactly two reads, the original pointer result, and no extra done afterwards.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_IMPL = 4'd0,  M_ACCU = 4'd1,  M_IMM  = 4'd2,  M_REL  = 4'd3,
        M_ZP   = 4'd4,  M_ZPX  = 4'd5,  M_ZPY  = 4'd6,  M_ABS  = 4'd7,
        M_ABSX = 4'd8,  M_ABSY = 4'd9,  M_IND  = 4'd10, M_INDX = 4'd11,
        M_INDY = 4'd12
    } mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] opnd;
        logic [DATA_W-1:0] ix;
        logic [DATA_W-1:0] iy;
    } req_t;

    typedef struct packed {
        logic              has_addr;
        logic              needs_ptr;
        logic [ADDR_W-1:0] direct;
        logic [ADDR_W-1:0] ptr_lo;
        logic [ADDR_W-1:0] ptr_hi;
    } plan_t;

    typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} fetch_st_e;

    function automatic logic [ADDR_W-1:0] page0(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] s;
        s = a + b;
        return {{(ADDR_W-DATA_W){1'b0}}, s};
    endfunction

    function automatic logic is_ptr_mode(input logic [MODE_W-1:0] m);
        return (m == M_IND) || (m == M_INDX) || (m == M_INDY);
    endfunction
endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  req_t  req,
    output plan_t plan
);
    localparam int PW = ADDR_W - DATA_W;
    logic [DATA_W-1:0] lo;
    logic [DATA_W-1:0] hi;

    assign lo = req.opnd[DATA_W-1:0];
    assign hi = req.opnd[ADDR_W-1:DATA_W];

    always_comb begin
        plan = '0;
        case (req.mode)
            M_IMM, M_REL, M_ZP: begin
                plan.has_addr = 1'b1;
                plan.direct   = {{PW{1'b0}}, lo};
            end
            M_ZPX: begin
                plan.has_addr = 1'b1;
                plan.direct   = page0(lo, req.ix);
            end
            M_ZPY: begin
                plan.has_addr = 1'b1;
                plan.direct   = page0(lo, req.iy);
            end
            M_ABS: begin
                plan.has_addr = 1'b1;
                plan.direct   = req.opnd;
            end
            M_ABSX: begin
                plan.has_addr = 1'b1;
                plan.direct   = req.opnd + {{PW{1'b0}}, req.ix};
            end
            M_ABSY: begin
                plan.has_addr = 1'b1;
                plan.direct   = req.opnd + {{PW{1'b0}}, req.iy};
            end
            M_IND: begin
                plan.has_addr  = 1'b1;
                plan.needs_ptr = 1'b1;
                plan.ptr_lo    = req.opnd;
                plan.ptr_hi    = {hi, lo + 8'd1};
            end
            M_INDX: begin
                plan.has_addr  = 1'b1;
                plan.needs_ptr = 1'b1;
                plan.ptr_lo    = page0(lo, req.ix);
                plan.ptr_hi    = page0(lo, req.ix + 8'd1);
            end
            M_INDY: begin
                plan.has_addr  = 1'b1;
                plan.needs_ptr = 1'b1;
                plan.ptr_lo    = {{PW{1'b0}}, lo};
                plan.ptr_hi    = page0(lo, 8'd1);
            end
            default: plan = '0;
        endcase
    end
endmodule

// File: rtl/eag_fetch.sv
module eag_fetch
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] ptr_lo,
    input  logic [ADDR_W-1:0] ptr_hi,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              ptr_done,
    output logic [ADDR_W-1:0] ptr_val
);
    fetch_st_e         st_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
            lo_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (go) st_q <= S_LO;
                S_LO: if (rd_valid) begin
                    lo_q <= rd_data;
                    st_q <= S_HI;
                end
                S_HI: if (rd_valid) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req  = (st_q != S_IDLE);
        busy    = rd_req;
        case (st_q)
            S_LO:    rd_addr = ptr_lo;
            S_HI:    rd_addr = ptr_hi;
            default: rd_addr = '0;
        endcase
        ptr_done = (st_q == S_HI) && rd_valid;
        ptr_val  = {rd_data, lo_q};
    end

    // R9: an open request keeps its address until served
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
    // R9: the low byte is always requested before the high byte
    assert_lo_first_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_req) |-> (st_q == S_LO));
endmodule

// File: rtl/eag_resolve.sv
module eag_resolve
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [DATA_W-1:0] iy,
    output logic [ADDR_W-1:0] ea
);
    always_comb begin
        if (mode == M_INDY) ea = ptr + {{(ADDR_W-DATA_W){1'b0}}, iy};
        else                ea = ptr;
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [eag_pkg::MODE_W-1:0] mode,
    input  logic [eag_pkg::ADDR_W-1:0] operand,
    input  logic [eag_pkg::DATA_W-1:0] idx_x,
    input  logic [eag_pkg::DATA_W-1:0] idx_y,
    output logic                      busy,
    output logic                      rd_req,
    output logic [eag_pkg::ADDR_W-1:0] rd_addr,
    input  logic                      rd_valid,
    input  logic [eag_pkg::DATA_W-1:0] rd_data,
    output logic                      done,
    output logic [eag_pkg::ADDR_W-1:0] addr,
    output logic                      addr_valid
);
    req_t              req_in, req_q;
    plan_t             plan_in, plan_q;
    logic              start_acc, go, ptr_done;
    logic [ADDR_W-1:0] ptr_val, ptr_ea;
    logic              done_q, valid_q;
    logic [ADDR_W-1:0] addr_q;

    assign req_in    = '{mode: mode, opnd: operand, ix: idx_x, iy: idx_y};
    assign start_acc = start && !busy;
    assign go        = start_acc && is_ptr_mode(mode);

    eag_decode u_dec_in (.req(req_in), .plan(plan_in));
    eag_decode u_dec_q  (.req(req_q),  .plan(plan_q));

    eag_fetch u_fetch (
        .clk(clk), .rst(rst), .go(go),
        .ptr_lo(plan_q.ptr_lo), .ptr_hi(plan_q.ptr_hi),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .ptr_done(ptr_done), .ptr_val(ptr_val)
    );

    eag_resolve u_res (.mode(req_q.mode), .ptr(ptr_val), .iy(req_q.iy), .ea(ptr_ea));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_acc) req_q <= req_in;
            if (ptr_done) begin
                done_q  <= 1'b1;
                valid_q <= 1'b1;
                addr_q  <= ptr_ea;
            end else if (start_acc && !plan_in.needs_ptr) begin
                done_q  <= 1'b1;
                valid_q <= plan_in.has_addr;
                addr_q  <= plan_in.direct;
            end
        end
    end

    assign done       = done_q;
    assign addr       = addr_q;
    assign addr_valid = valid_q;

    // R10: no read is outstanding while a result is reported
    assert_done_no_req_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);
    // R1: a result without an address is all zero
    assert_noaddr_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !addr_valid) |-> (addr == '0));
    // R4: zero-page results never leave page 0
    assert_zp_page0_R4: assert property (@(posedge clk) disable iff (rst)
        (done && (req_q.mode inside {M_ZP, M_ZPX, M_ZPY}))
            |-> (addr[ADDR_W-1:DATA_W] == '0));
    // R8: the high pointer byte of the indirect mode stays in the operand page
    assert_ind_page_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (req_q.mode == M_IND))
            |-> (rd_addr[ADDR_W-1:DATA_W] == req_q.opnd[ADDR_W-1:DATA_W]));
    // R11: a start during a fetch leaves the captured request unchanged
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));
endmodule

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] operand = '0;
    logic [7:0]  idx_x = '0, idx_y = '0;
    logic        busy, rd_req, done, addr_valid;
    logic [15:0] rd_addr, addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lat = 0;
    int cnt = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eff_addr_gen i_eff_addr_gen (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
        .idx_x(idx_x), .idx_y(idx_y), .busy(busy), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .addr(addr), .addr_valid(addr_valid)
    );

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return (a[7:0] + 8'h37) ^ a[15:8];
    endfunction

    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid <= 1'b0;
            cnt      <= 0;
        end else if (rd_req) begin
            if (cnt >= lat) begin
                rd_valid <= 1'b1;
                rd_data  <= mem_at(rd_addr);
            end else cnt <= cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic drive(input logic [3:0] m, input logic [15:0] op,
                         input logic [7:0] x, input logic [7:0] y);
        mode = m; operand = op; idx_x = x; idx_y = y; start = 1'b1;
    endtask

    // run one operation; reads and timing are observed at the ports
    task automatic run_op(input logic [3:0] m, input logic [15:0] op,
                          input logic [7:0] x, input logic [7:0] y, input int latency,
                          input logic [15:0] exp_a, input bit exp_v, input int exp_n,
                          input logic [15:0] r0, input logic [15:0] r1, input string req);
        int s, last, n, guard;
        logic [15:0] seen0, seen1;
        lat = latency;
        step();
        drive(m, op, x, y);
        s = cyc;
        step();
        start = 1'b0;
        n = 0; last = -1; guard = 0; seen0 = '0; seen1 = '0;
        while (!done && guard < 60) begin
            if (rd_req && rd_valid) begin
                if (n == 0) seen0 = rd_addr; else seen1 = rd_addr;
                n++;
                last = cyc;
            end
            step();
            guard++;
        end
        chk(done == 1'b1, {req, " done seen"}, done, 1);
        chk(addr == exp_a, {req, " address"}, addr, exp_a);
        chk(addr_valid == exp_v, {req, " addr_valid"}, addr_valid, exp_v);
        chk(n == exp_n, {req, " read count"}, n, exp_n);
        if (exp_n > 0) begin
            chk(seen0 == r0, {req, " low pointer address"}, seen0, r0);
            chk(seen1 == r1, {req, " high pointer address"}, seen1, r1);
            chk(cyc == last + 1, {req, " R10 done after high byte"}, cyc, last + 1);
        end else begin
            chk(cyc == s + 1, {req, " done one cycle after start"}, cyc, s + 1);
        end
        step();
        chk(done == 1'b0, {req, " R10 done single pulse"}, done, 0);
        chk(addr == exp_a, {req, " R10 result held"}, addr, exp_a);
    endtask

    task automatic test_reset();
        chk(!done && !rd_req && !busy, "R13 control outputs low", {done, rd_req, busy}, 0);
        chk(!addr_valid && addr == 16'h0, "R13 result cleared", {addr_valid, addr}, 0);
    endtask

    task automatic test_noaddr();
        run_op(4'd0, 16'h1234, 8'h11, 8'h22, 0, 16'h0000, 0, 0, 0, 0, "R1 implied");
        run_op(4'd1, 16'hBEEF, 8'h00, 8'h00, 0, 16'h0000, 0, 0, 0, 0, "R1 accumulator");
        run_op(4'd15, 16'h4321, 8'h00, 8'h00, 0, 16'h0000, 0, 0, 0, 0, "R1 unused code");
    endtask

    task automatic test_direct();
        run_op(4'd2, 16'hAB77, 8'h05, 8'h06, 0, 16'h0077, 1, 0, 0, 0, "R2 immediate");
        run_op(4'd3, 16'h00F0, 8'h05, 8'h06, 0, 16'h00F0, 1, 0, 0, 0, "R2 relative");
        run_op(4'd4, 16'h5544, 8'h05, 8'h06, 0, 16'h0044, 1, 0, 0, 0, "R3 zero page");
        run_op(4'd5, 16'h00F0, 8'h20, 8'h00, 0, 16'h0010, 1, 0, 0, 0, "R4 zp+X wrap");
        run_op(4'd6, 16'h0080, 8'h00, 8'h7F, 0, 16'h00FF, 1, 0, 0, 0, "R4 zp+Y");
        run_op(4'd7, 16'h1234, 8'h10, 8'h10, 0, 16'h1234, 1, 0, 0, 0, "R5 absolute");
        run_op(4'd8, 16'h12F0, 8'h20, 8'h00, 0, 16'h1310, 1, 0, 0, 0, "R5 abs+X carry");
        run_op(4'd9, 16'hFFF0, 8'h00, 8'h20, 0, 16'h0010, 1, 0, 0, 0, "R5 abs+Y wrap");
    endtask

    task automatic test_pointer();
        run_op(4'd11, 16'h00FE, 8'h01, 8'h00, 2, {mem_at(16'h0000), mem_at(16'h00FF)},
               1, 2, 16'h00FF, 16'h0000, "R6 indexed indirect wrap");
        run_op(4'd11, 16'h0030, 8'h05, 8'h00, 0, {mem_at(16'h0036), mem_at(16'h0035)},
               1, 2, 16'h0035, 16'h0036, "R6 indexed indirect");
        run_op(4'd12, 16'h00FF, 8'h00, 8'h10, 0,
               {mem_at(16'h0000), mem_at(16'h00FF)} + 16'h0010,
               1, 2, 16'h00FF, 16'h0000, "R7 indirect indexed wrap");
        run_op(4'd12, 16'h0040, 8'h00, 8'hF0, 3,
               {mem_at(16'h0041), mem_at(16'h0040)} + 16'h00F0,
               1, 2, 16'h0040, 16'h0041, "R7 R9 indirect indexed slow");
        run_op(4'd10, 16'h12FF, 8'h00, 8'h00, 1, {mem_at(16'h1200), mem_at(16'h12FF)},
               1, 2, 16'h12FF, 16'h1200, "R8 indirect page bug");
        run_op(4'd10, 16'h3440, 8'h00, 8'h00, 0, {mem_at(16'h3441), mem_at(16'h3440)},
               1, 2, 16'h3440, 16'h3441, "R8 indirect");
    endtask

    task automatic test_busy_start();
        int n, guard, extra;
        logic [15:0] exp_a;
        exp_a = {mem_at(16'h0041), mem_at(16'h0040)} + 16'h0001;
        lat = 4;
        step();
        drive(4'd12, 16'h0040, 8'h00, 8'h01);
        step();
        start = 1'b0;
        step();
        drive(4'd4, 16'h0099, 8'h00, 8'h00);
        step();
        start = 1'b0;
        n = 0; guard = 0;
        while (!done && guard < 60) begin
            if (rd_req && rd_valid) n++;
            step();
            guard++;
        end
        chk(done && addr == exp_a, "R11 running fetch result kept", addr, exp_a);
        chk(n == 2, "R11 read count", n, 2);
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (done) extra++;
        end
        chk(extra == 0, "R11 no extra done", extra, 0);
    endtask

    task automatic test_back_to_back();
        int guard;
        lat = 0;
        step();
        drive(4'd4, 16'h0021, 8'h00, 8'h00);
        step();
        drive(4'd7, 16'hC0DE, 8'h00, 8'h00);
        chk(done && addr == 16'h0021, "R12 first result in overlap cycle", addr, 16'h0021);
        step();
        start = 1'b0;
        chk(done && addr == 16'hC0DE, "R12 second result next cycle", addr, 16'hC0DE);
        drive(4'd11, 16'h0010, 8'h02, 8'h00);
        step();
        start = 1'b0;
        guard = 0;
        while (!done && guard < 60) begin
            step();
            guard++;
        end
        chk(done && addr == {mem_at(16'h0013), mem_at(16'h0012)},
            "R12 pointer op after overlap", addr, {mem_at(16'h0013), mem_at(16'h0012)});
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        test_reset();
        test_noaddr();
        test_direct();
        test_pointer();
        test_busy_start();
        test_back_to_back();
        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule